// File: doc/BRIEF.md
# Reset Sequencer with Vector Fetch

This block gathers every reset source of a small 8-bit processor core and turns them into a single internal reset and a start-up sequence. A power-on indication forces reset at once, without waiting for a clock. Once power-on is removed, a two-flop synchronizer times the release to the internal clock. The block then waits out an oscillator-stabilization interval. The interval is long by default, and a configuration input picks a short one. The external reset pin arrives already filtered by a Schmitt trigger. The block samples it on both clock edges, so a low pulse is accepted only after it has lasted one and a half clock cycles. Watchdog-style internal requests are also combined.

When every source is quiet, the block drives the vector address onto the bus for a few idle cycles. It then reads the high vector byte and the low vector byte on two consecutive strobes and joins them into the program counter. It pulses `done` in the first cycle of normal operation, and in that same cycle the first opcode fetch goes out from the new program counter. Any new request during the sequence sends it back to the hold state, and the sequence starts over.

Top module: `rstseq_top`

## Requirements
- R1: While `por` is high, `rst_out` is high at once, with no clock edge needed. During that time `rd_en` and `done` are low and `addr` shows 0x07FE.
- R2: After `por` falls with `osc_ok` high and `fast_stab` low, `done` first reads high after rising edge number SLOW_CYC+PREP_CYC+6 (4073), counted from the fall of `por`. Counting only advances while `osc_ok` is high. When `osc_ok` rises late, `done` follows on edge FAST_CYC+PREP_CYC+4 (135 with the fast interval) after that rise.
- R3: When `fast_stab` is high, the interval is FAST_CYC (128) cycles, so `done` comes on edge 137 after `por` falls.
- R4: `fast_stab` is captured while the count is idle. Changing it after counting has begun has no effect on the length.
- R5: If any source is still active when the interval ends, `rst_out` stays high. `done` then comes on edge PREP_CYC+4 (7) after the last source goes quiet.
- R6: A low on `ext_rst_n` that covers at most two half-cycle samples is ignored, and `rst_out` stays low. A low covering three consecutive half-cycle samples (1.5 cycles) is accepted.
- R7: If a held-low `ext_rst_n` returns high before the falling clock edge, `done` comes on rising edge PREP_CYC+5 (8) after the return.
- R8: Any set bit of `int_req` forces reset. `done` comes on edge PREP_CYC+4 after it clears.
- R9: The fetch sequence is PREP_CYC cycles of `addr` = 0x07FE with `rd_en` low, then `rd_en` high with 0x07FE, then `rd_en` high with 0x07FF on the next cycle. Read data is taken from `rd_data` in the cycle after each strobe.
- R10: `done` is high for exactly one cycle. In that cycle `pc` = {high byte, low byte}, `rst_out` is low, `rd_en` is high and `addr` equals `pc`.
- R11: A request that arrives during the sequence sends it back to the start. Exactly one `done` follows, on edge PREP_CYC+4 after the request clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por | input | 1 | Power-on reset indication, active high, asynchronous |
| ext_rst_n | input | 1 | Filtered external reset pin, active low |
| int_req | input | REQ_W | Internal reset requests (watchdog and similar) |
| osc_ok | input | 1 | Oscillator running |
| fast_stab | input | 1 | Selects the short stabilization interval |
| rd_data | input | 8 | Data bus, valid in the cycle after a strobe |
| rst_out | output | 1 | Internal reset, active high |
| addr | output | 16 | Address bus |
| rd_en | output | 1 | Read strobe |
| pc | output | 16 | Loaded program counter |
| done | output | 1 | One-cycle pulse when the program counter is loaded |

## Verification
The bench times each release path and compares the result against edge counts it works out itself. A counter that is off by one, or a synchronizer that is missing, moves `done` by a cycle and shows up as a mismatch. It sends external pulses of one, two and three half-cycle samples. A qualifier that counted whole cycles would either ignore the 12 ns pulse or accept the 8 ns pulse. It also changes `fast_stab` in the middle of a count, which catches a select that is not latched. It fires a request during the idle address cycles and checks that only one program counter load follows. A scoreboard of expected strobe addresses and loaded vectors catches swapped byte order and a low-byte fetch at the wrong address.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PREP,
    ST_VHI,
    ST_VLO,
    ST_LOAD,
    ST_RUN
  } seq_state_e;

  // Length of a trailing run of low half-cycle samples, saturating at three.
  function automatic logic [1:0] low_run_next(input logic [1:0] run, input logic smp);
    if (smp) return 2'd0;
    else if (run == 2'd3) return 2'd3;
    else return run + 2'd1;
  endfunction

  // Stabilization interval in clock cycles for the chosen setting.
  function automatic int unsigned stab_len(input logic fast, input int unsigned slow_cyc,
                                           input int unsigned fast_cyc);
    return fast ? fast_cyc : slow_cyc;
  endfunction

endpackage

// File: rtl/rstseq_pinqual.sv
module rstseq_pinqual
  import rstseq_pkg::*;
(
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  output logic hold
);

  logic       neg_smp;
  logic [1:0] run_q;
  logic [1:0] run_a;
  logic [1:0] run_b;
  logic       qual_ev;

  // falling-edge half of the sampling
  always_ff @(negedge clk or posedge por) begin
    if (por) neg_smp <= 1'b1;
    else     neg_smp <= pin_n;
  end

  // negedge sample is older than the posedge sample
  always_comb begin
    run_a   = low_run_next(run_q, neg_smp);
    run_b   = low_run_next(run_a, pin_n);
    qual_ev = (run_a == 2'd3) || (run_b == 2'd3);
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      run_q <= 2'd0;
      hold  <= 1'b0;
    end else begin
      run_q <= run_b;
      if (qual_ev)    hold <= 1'b1;
      else if (pin_n) hold <= 1'b0;
    end
  end

  // R6: acceptance always involves a low falling-edge sample
  a_r6_hold_needs_low_half: assert property (@(posedge clk) disable iff (por)
    $rose(hold) |-> !$past(neg_smp));

  // R6: with both half samples high the hold is released
  a_r6_hold_drops_on_high: assert property (@(posedge clk) disable iff (por)
    (hold && pin_n && neg_smp) |=> !hold);

endmodule

// File: rtl/rstseq_stab.sv
module rstseq_stab
  import rstseq_pkg::*;
#(
  parameter int unsigned SLOW_CYC = 4064,
  parameter int unsigned FAST_CYC = 128
) (
  input  logic clk,
  input  logic por,
  input  logic osc_ok,
  input  logic fast_sel,
  output logic stab_done
);

  localparam int CW = $clog2(SLOW_CYC + 1);

  logic [1:0]    sync_q;
  logic          released;
  logic          fast_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          count_en;

  // two-flop release synchronizer, asserted asynchronously
  always_ff @(posedge clk or posedge por) begin
    if (por) sync_q <= 2'b00;
    else     sync_q <= {sync_q[0], 1'b1};
  end

  always_comb begin
    released = sync_q[1];
    count_en = released && osc_ok && !stab_done;
    lim      = CW'(stab_len(fast_q, SLOW_CYC, FAST_CYC) - 1);
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      fast_q    <= 1'b0;
      cnt       <= '0;
      stab_done <= 1'b0;
    end else begin
      if (cnt == '0 && !count_en && !stab_done) fast_q <= fast_sel;
      if (count_en) begin
        cnt <= cnt + 1'b1;
        if (cnt == lim) stab_done <= 1'b1;
      end
    end
  end

  // R2: no progress while the oscillator is idle
  a_r2_idle_without_osc: assert property (@(posedge clk) disable iff (por)
    (!osc_ok && !stab_done) |=> ($stable(cnt) && !stab_done));

  // R4: the interval select cannot move once counting has begun
  a_r4_select_frozen: assert property (@(posedge clk) disable iff (por)
    (cnt != '0) |=> $stable(fast_q));

  // R3: completion only at the selected limit
  a_r3_done_at_limit: assert property (@(posedge clk) disable iff (por)
    $rose(stab_done) |-> ($past(cnt) == $past(lim)));

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int unsigned PREP_CYC = 3,
  parameter logic [15:0] VEC_ADDR = 16'h07FE
) (
  input  logic        clk,
  input  logic        por,
  input  logic        src_active,
  input  logic [7:0]  rd_data,
  output logic        rst_out,
  output logic [15:0] addr,
  output logic        rd_en,
  output logic [15:0] pc,
  output logic        done
);

  localparam int          PW     = $clog2(PREP_CYC + 1);
  localparam logic [15:0] VEC_LO = VEC_ADDR + 16'd1;
  localparam logic [PW-1:0] PREP_LAST = PW'(PREP_CYC - 1);

  seq_state_e    state;
  seq_state_e    state_nx;
  logic [PW-1:0] prep_cnt;
  logic [7:0]    hi_q;
  logic          fetch_hi_ev;
  logic          load_ev;

  always_comb begin
    state_nx = state;
    if (src_active) state_nx = ST_HOLD;
    else begin
      case (state)
        ST_HOLD: state_nx = ST_PREP;
        ST_PREP: if (prep_cnt == PREP_LAST) state_nx = ST_VHI;
        ST_VHI:  state_nx = ST_VLO;
        ST_VLO:  state_nx = ST_LOAD;
        ST_LOAD: state_nx = ST_RUN;
        default: state_nx = ST_RUN;
      endcase
    end
    fetch_hi_ev = (state == ST_VHI) && !src_active;
    load_ev     = (state == ST_LOAD) && !src_active;
  end

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      state    <= ST_HOLD;
      prep_cnt <= '0;
      hi_q     <= 8'h00;
      pc       <= 16'h0000;
      done     <= 1'b0;
    end else begin
      state    <= state_nx;
      prep_cnt <= (state == ST_PREP && !src_active) ? prep_cnt + 1'b1 : '0;
      if (state == ST_VLO) hi_q <= rd_data;
      if (load_ev) pc <= {hi_q, rd_data};
      done     <= load_ev;
    end
  end

  always_comb begin
    rst_out = por || (state != ST_RUN);
    rd_en   = (state == ST_VHI) || (state == ST_VLO) || (state == ST_RUN);
    if (state == ST_RUN)                            addr = pc;
    else if (state == ST_VLO || state == ST_LOAD)  addr = VEC_LO;
    else                                            addr = VEC_ADDR;
  end

  // R9: the low vector byte is strobed right after the high byte
  a_r9_lo_after_hi: assert property (@(posedge clk) disable iff (por)
    fetch_hi_ev |=> (rd_en && addr == VEC_LO && rst_out));

  // R10: single-cycle completion pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (por)
    done |=> !done);

  // R10: completion coincides with the first fetch from the new counter
  a_r10_done_releases: assert property (@(posedge clk) disable iff (por)
    done |-> (!rst_out && rd_en && addr == pc));

  // R11: any active source returns the block to reset
  a_r11_src_forces_reset: assert property (@(posedge clk) disable iff (por)
    src_active |=> (rst_out && !done));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int unsigned SLOW_CYC = 4064,
  parameter int unsigned FAST_CYC = 128,
  parameter int unsigned PREP_CYC = 3,
  parameter int unsigned REQ_W    = 2,
  parameter logic [15:0] VEC_ADDR = 16'h07FE
) (
  input  logic             clk,
  input  logic             por,
  input  logic             ext_rst_n,
  input  logic [REQ_W-1:0] int_req,
  input  logic             osc_ok,
  input  logic             fast_stab,
  input  logic [7:0]       rd_data,
  output logic             rst_out,
  output logic [15:0]      addr,
  output logic             rd_en,
  output logic [15:0]      pc,
  output logic             done
);

  logic ext_hold;
  logic stab_done;
  logic src_active;

  rstseq_pinqual u_qual (
    .clk   (clk),
    .por   (por),
    .pin_n (ext_rst_n),
    .hold  (ext_hold)
  );

  rstseq_stab #(
    .SLOW_CYC (SLOW_CYC),
    .FAST_CYC (FAST_CYC)
  ) u_stab (
    .clk       (clk),
    .por       (por),
    .osc_ok    (osc_ok),
    .fast_sel  (fast_stab),
    .stab_done (stab_done)
  );

  assign src_active = ext_hold || (|int_req) || !stab_done;

  rstseq_fsm #(
    .PREP_CYC (PREP_CYC),
    .VEC_ADDR (VEC_ADDR)
  ) u_fsm (
    .clk        (clk),
    .por        (por),
    .src_active (src_active),
    .rd_data    (rd_data),
    .rst_out    (rst_out),
    .addr       (addr),
    .rd_en      (rd_en),
    .pc         (pc),
    .done       (done)
  );

  // R5: reset stays up while the interval is unfinished
  a_r5_hold_until_stable: assert property (@(posedge clk) disable iff (por)
    !stab_done |=> rst_out);

endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;

  localparam int PREP = 3;
  localparam int SLOW = 4064;
  localparam int FAST = 128;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        ext_rst_n = 1'b1;
  logic [1:0]  int_req = 2'b00;
  logic        osc_ok = 1'b1;
  logic        fast_stab = 1'b1;
  logic [7:0]  rd_data = 8'h00;
  logic        rst_out;
  logic [15:0] addr;
  logic        rd_en;
  logic [15:0] pc;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  logic [7:0] vec_hi = 8'hAB;
  logic [7:0] vec_lo = 8'hCD;
  logic [16:0] exp_q[$];

  always #4 clk = ~clk;

  rstseq_top uut (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .int_req(int_req), .osc_ok(osc_ok),
    .fast_stab(fast_stab), .rd_data(rd_data), .rst_out(rst_out), .addr(addr),
    .rd_en(rd_en), .pc(pc), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // driver: expected strobes and loaded vector for one sequence
  task automatic expect_seq(input logic [7:0] hi, input logic [7:0] lo);
    vec_hi = hi;
    vec_lo = lo;
    exp_q.push_back({1'b0, 16'h07FE});
    exp_q.push_back({1'b0, 16'h07FF});
    exp_q.push_back({1'b1, hi, lo});
  endtask

  task automatic run_to_done(output int n, output int early);
    n = 0;
    early = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) break;
      if (!rst_out) early++;
      if (n > 20000) break;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // memory model: byte appears in the cycle after the strobe
  initial begin
    logic [7:0] pend;
    forever begin
      @(negedge clk);
      if (rd_en) pend = (addr == 16'h07FE) ? vec_hi : (addr == 16'h07FF) ? vec_lo : 8'hA5;
      else       pend = 8'h00;
      @(posedge clk);
      #2;
      rd_data = pend;
    end
  end

  // monitor: pops expected items as strobes and completions appear
  initial begin
    forever begin
      @(negedge clk);
      if (!por) begin
        if (done) begin
          done_cnt++;
          if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", {16'h0, pc}, 32'h0);
          else begin
            logic [16:0] it;
            it = exp_q.pop_front();
            chk(it[16] && pc == it[15:0], "R10 loaded pc", {16'h0, pc}, {16'h0, it[15:0]});
            chk(!rst_out && rd_en && addr == pc, "R10 first fetch", {16'h0, addr}, {16'h0, pc});
          end
        end else if (rst_out && rd_en) begin
          if (exp_q.size() == 0) chk(1'b0, "R9 unexpected strobe", {16'h0, addr}, 32'h0);
          else begin
            logic [16:0] it;
            it = exp_q.pop_front();
            chk(!it[16] && addr == it[15:0], "R9 vector strobe", {16'h0, addr},
                {16'h0, it[15:0]});
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    int n;
    int early;
    int dc;
    logic seen;

    // R1 reset state
    #20;
    chk(rst_out && !rd_en && !done && addr == 16'h07FE, "R1 reset state",
        {rst_out, rd_en, done, addr}, {3'b100, 16'h07FE});

    // R3 fast interval from power-on
    step(1);
    expect_seq(8'hAB, 8'hCD);
    por = 1'b0;
    run_to_done(n, early);
    chk(n == FAST + PREP + 6 && early == 0, "R3 fast release edge", n, FAST + PREP + 6);

    // R1 asynchronous power-on assertion
    step(3);
    por = 1'b1;
    #1;
    chk(rst_out == 1'b1, "R1 async assert", rst_out, 1);
    step(1);
    chk(!done && !rd_en && addr == 16'h07FE, "R1 held state", {done, rd_en, addr},
        {2'b00, 16'h07FE});

    // R2 and R4: slow interval, select toggled after count began
    fast_stab = 1'b0;
    expect_seq(8'h12, 8'hF0);
    por = 1'b0;
    fork
      run_to_done(n, early);
      begin step(20); fast_stab = 1'b1; end
    join
    chk(n == SLOW + PREP + 6 && early == 0, "R2 R4 slow release edge", n, SLOW + PREP + 6);

    // R4: fast select captured, later change ignored
    step(2);
    por = 1'b1;
    step(2);
    fast_stab = 1'b1;
    expect_seq(8'h3C, 8'h5A);
    por = 1'b0;
    fork
      run_to_done(n, early);
      begin step(10); fast_stab = 1'b0; end
    join
    chk(n == FAST + PREP + 6, "R4 fast select kept", n, FAST + PREP + 6);

    // R2: counting waits for the oscillator
    step(2);
    por = 1'b1;
    osc_ok = 1'b0;
    fast_stab = 1'b1;
    step(2);
    expect_seq(8'h77, 8'h01);
    por = 1'b0;
    step(10);
    chk(rst_out && !done, "R2 waits for osc", {rst_out, done}, 2'b10);
    osc_ok = 1'b1;
    run_to_done(n, early);
    chk(n == FAST + PREP + 4, "R2 late osc edge", n, FAST + PREP + 4);

    // R5: source still active when the interval ends
    step(2);
    por = 1'b1;
    int_req = 2'b10;
    step(2);
    expect_seq(8'h44, 8'h88);
    por = 1'b0;
    dc = done_cnt;
    step(200);
    chk(rst_out && done_cnt == dc, "R5 held past interval", {rst_out, done_cnt - dc}, 1 << 0);
    int_req = 2'b00;
    run_to_done(n, early);
    chk(n == PREP + 4, "R5 release after source", n, PREP + 4);

    // R8: internal request from normal operation
    step(3);
    expect_seq(8'h12, 8'h34);
    int_req = 2'b01;
    step(1);
    @(negedge clk);
    chk(rst_out == 1'b1, "R8 request asserts reset", rst_out, 1);
    step(2);
    int_req = 2'b00;
    run_to_done(n, early);
    chk(n == PREP + 4, "R8 release edge", n, PREP + 4);

    // R11: request during the idle address cycles restarts
    step(3);
    expect_seq(8'h56, 8'h78);
    dc = done_cnt;
    int_req = 2'b01;
    step(1);
    int_req = 2'b00;
    step(2);
    chk(rst_out && !rd_en, "R11 in prep", {rst_out, rd_en}, 2'b10);
    int_req = 2'b10;
    step(1);
    int_req = 2'b00;
    run_to_done(n, early);
    chk(n == PREP + 4, "R11 restart edge", n, PREP + 4);
    step(3);
    chk(done_cnt - dc == 1, "R11 single completion", done_cnt - dc, 1);

    // R6: one half-cycle and two half-cycle lows are ignored
    ext_rst_n = 1'b0;
    #4;
    ext_rst_n = 1'b1;
    step(1);
    ext_rst_n = 1'b0;
    #8;
    ext_rst_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rst_out) seen = 1'b1;
    end
    chk(!seen, "R6 short pulses ignored", seen, 0);

    // R6: three half-cycle samples accepted
    step(1);
    expect_seq(8'h9A, 8'hBC);
    ext_rst_n = 1'b0;
    #12;
    ext_rst_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (rst_out) seen = 1'b1;
    end
    chk(seen, "R6 1.5 cycle pulse accepted", seen, 1);
    run_to_done(n, early);
    chk(n < 20, "R6 sequence completes", n, 20);

    // R7: release latency after a long external low
    step(3);
    expect_seq(8'hDE, 8'hAD);
    ext_rst_n = 1'b0;
    step(5);
    ext_rst_n = 1'b1;
    run_to_done(n, early);
    chk(n == PREP + 5, "R7 external release edge", n, PREP + 5);

    step(3);
    chk(exp_q.size() == 0, "R9 all expected items seen", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule